// File: doc/BRIEF.md
# Broadcast Support Vector Element Array

This block holds a small set of stored training vectors, one per support vector element, and runs them through four fixed phases. First the vectors and their ±1 class labels are streamed in. The array then works out the kernel matrix one row at a time. A single broadcast register feeds one stored vector, component by component, to every element at once, so all N kernel terms of a row finish together.

Next an external learning engine writes the per-element multipliers and a shared bias. In the recall phase, test vectors are streamed over the same broadcast register. Each element forms its weighted and signed kernel term. A pipelined adder tree sums the terms, the bias is added, and the sign of the result is the class decision. The kernel is the quadratic polynomial (x·x_m + 1)², computed in integer fixed point with a wide dot-product accumulator.

Top module: `svm_bus_array`

## Requirements
- R1: Reset puts the phase output at 0. The phases are encoded 0 load, 1 kernel, 2 learn and 3 recall. The phase only steps forward one code at a time and stays at 3 until the next reset. krow_valid and cls_valid are low during reset.
- R2: In phase 0, each cycle with ld_valid high stores one signed component. The order is component 0 to D-1 of vector 0, then of vector 1, and so on. The ld_label value given with the final component of a vector sets its class (1 means +1, 0 means -1). In the cycle after the N·D-th accepted component, the phase reads 1. ld_valid has no effect in any other phase.
- R3: Phase 1 lasts N·D cycles and then moves to 2. The stored vectors are broadcast in index order, one component per cycle. krow_valid pulses for one cycle per row, with krow_idx equal to the row. Counting the first cycle of phase 1 as cycle 0, row r appears in cycle D·(r+1)+1.
- R4: While krow_valid is high, bits [ACC·e +: ACC] of krow_data hold (x_r·x_e + 1)² modulo 2^ACC, for every element e.
- R5: In phase 2, a write with pw_addr below N sets that element's unsigned multiplier. pw_addr equal to N sets the signed bias. Higher addresses are ignored. Writes in any other phase are ignored. Reset clears all multipliers and the bias to 0.
- R6: pw_done high in phase 2 makes the phase read 3 in the next cycle. A write presented in that same cycle still takes effect.
- R7: In phase 3, each cycle with tv_valid high delivers the next test component, with D components per vector. Vectors may follow each other without gaps. tv_valid has no effect in other phases. cls_valid pulses once per vector, log2(N)+4 cycles after the cycle that delivers the final component.
- R8: cls_out is 1 only when the sum over m of alpha_m·s_m·K(x, x_m), plus the bias, is strictly greater than 0. Here s_m is +1 or -1 from the label, and a -1 label negates the term. A sum of exactly 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load component strobe |
| ld_data | input | W | Signed training vector component |
| ld_label | input | 1 | Class of the vector being loaded (1 = +1) |
| pw_valid | input | 1 | Parameter write strobe |
| pw_addr | input | $clog2(N+1) | Multiplier index, or N for the bias |
| pw_data | input | W | Multiplier (unsigned) or bias (signed) |
| pw_done | input | 1 | Learning finished |
| tv_valid | input | 1 | Test component strobe |
| tv_data | input | W | Signed test vector component |
| phase | output | 2 | Current phase code |
| krow_valid | output | 1 | Kernel row present |
| krow_idx | output | $clog2(N) | Index of the broadcast row |
| krow_data | output | N·ACC | Kernel values, one slice per element |
| cls_valid | output | 1 | Class decision present |
| cls_out | output | 1 | 1 for +1, 0 for -1 |

## Verification
The embedded assertions check, on every cycle, the legal phase stepping and the conditions for leaving load and learn. They also check that kernel rows come out only in the kernel and learn phases, and class results only in recall. The kernel values, the result timing, the ignoring of strobes outside their phase, the label negation and the exact-zero decision can only be shown by the bench scenarios. Those scenarios compare against an independent arithmetic model on every clock.

// File: rtl/svm_bus_array.sv
module svm_bus_array #(
  parameter int N = 4,
  parameter int D = 4,
  parameter int W = 16,
  parameter int ACC = 40,
  localparam int AW = $clog2(N + 1),
  localparam int RW = $clog2(N),
  localparam int CW = $clog2(D),
  localparam int LN = $clog2(N),
  localparam int SW = ACC + W + 1 + LN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  input  logic [W-1:0]        ld_data,
  input  logic                ld_label,
  input  logic                pw_valid,
  input  logic [AW-1:0]       pw_addr,
  input  logic [W-1:0]        pw_data,
  input  logic                pw_done,
  input  logic                tv_valid,
  input  logic [W-1:0]        tv_data,
  output logic [1:0]          phase,
  output logic                krow_valid,
  output logic [RW-1:0]       krow_idx,
  output logic [N*ACC-1:0]    krow_data,
  output logic                cls_valid,
  output logic                cls_out
);
  localparam logic [1:0] P_LOAD = 2'd0, P_KERN = 2'd1, P_LEARN = 2'd2, P_RECALL = 2'd3;
  localparam int A1 = ACC + 1;

  logic signed [W-1:0]   mem [N][D];
  logic [N-1:0]          lab;
  logic [W-1:0]          alpha [N];
  logic signed [W-1:0]   bias;
  logic [RW-1:0]         r_cnt;
  logic [CW-1:0]         c_cnt;
  logic signed [W-1:0]   bus_d;
  logic [CW-1:0]         bus_c;
  logic [RW-1:0]         bus_row;
  logic                  bus_v, bus_last, bus_kern;
  logic signed [ACC-1:0] acc [N];
  logic                  rdy, rdy_kern;
  logic [RW-1:0]         rdy_row;
  logic signed [SW-1:0]  tr [1:2*N-1];
  logic signed [SW-1:0]  total;
  logic [LN:0]           pv;

  wire last_c = c_cnt == CW'(D - 1);
  wire last_r = r_cnt == RW'(N - 1);
  wire ld_go  = phase == P_LOAD && ld_valid;
  wire kn_go  = phase == P_KERN;
  wire tv_go  = phase == P_RECALL && tv_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_LOAD;
      r_cnt <= '0;
      c_cnt <= '0;
    end else begin
      if (ld_go || kn_go || tv_go) begin
        c_cnt <= last_c ? '0 : c_cnt + 1'b1;
        if (last_c && !tv_go) r_cnt <= last_r ? '0 : r_cnt + 1'b1;
        if (last_c && last_r && !tv_go) phase <= phase + 2'd1;
      end
      if (phase == P_LEARN && pw_done) phase <= P_RECALL;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_go) begin
      mem[r_cnt][c_cnt] <= ld_data;
      if (last_c) lab[r_cnt] <= ld_label;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) alpha[i] <= '0;
      bias <= '0;
    end else if (phase == P_LEARN && pw_valid) begin
      if (pw_addr < AW'(N)) alpha[pw_addr[RW-1:0]] <= pw_data;
      else if (pw_addr == AW'(N)) bias <= pw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_v <= 1'b0; bus_last <= 1'b0; bus_kern <= 1'b0;
      bus_d <= '0; bus_c <= '0; bus_row <= '0;
      rdy <= 1'b0; rdy_kern <= 1'b0; rdy_row <= '0;
      pv <= '0; cls_valid <= 1'b0; cls_out <= 1'b0;
    end else begin
      bus_v    <= kn_go || tv_go;
      bus_d    <= kn_go ? mem[r_cnt][c_cnt] : tv_data;
      bus_c    <= c_cnt;
      bus_row  <= r_cnt;
      bus_last <= last_c;
      bus_kern <= kn_go;
      rdy      <= bus_v && bus_last;
      rdy_kern <= bus_kern;
      rdy_row  <= bus_row;
      pv       <= {pv[LN-1:0], rdy && !rdy_kern};
      cls_valid <= pv[LN];
      if (pv[LN]) cls_out <= !total[SW-1] && total != '0;
    end
  end

  for (genvar e = 0; e < N; e++) begin : g_sve
    logic signed [2*W-1:0] prd;
    logic signed [A1-1:0]  a1;
    logic [ACC-1:0]        kv;
    logic [W+ACC-1:0]      prod;
    logic signed [SW-1:0]  term;
    assign prd  = bus_d * mem[e][bus_c];
    assign a1   = A1'(acc[e]) + A1'(1);
    assign kv   = ACC'(a1 * a1);
    assign prod = alpha[e] * kv;
    assign term = lab[e] ? SW'(prod) : -SW'(prod);
    assign krow_data[e*ACC +: ACC] = kv;
    always_ff @(posedge clk) begin
      if (bus_v) acc[e] <= (bus_c == '0 ? '0 : acc[e]) + ACC'(prd);
      if (rdy && !rdy_kern) tr[N+e] <= term;
    end
  end

  for (genvar i = 1; i < N; i++) begin : g_tree
    always_ff @(posedge clk) tr[i] <= tr[2*i] + tr[2*i+1];
  end

  assign total      = tr[1] + SW'(bias);
  assign krow_valid = rdy && rdy_kern;
  assign krow_idx   = rdy_row;

  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase == $past(phase)) || ($past(phase) != P_RECALL && phase == $past(phase) + 2'd1));
  a_r2_load_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_KERN && $past(phase) == P_LOAD) |-> $past(ld_valid));
  a_r6_learn_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_RECALL && $past(phase) == P_LEARN) |-> $past(pw_done));
  a_r3_krow_window: assert property (@(posedge clk) disable iff (!rst_n)
    krow_valid |-> (phase == P_KERN || phase == P_LEARN));
  a_r7_cls_window: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> phase == P_RECALL);
endmodule

// File: tb/svm_bus_array_bench.sv
`timescale 1ns/1ps
module svm_bus_array_bench;
  localparam int N = 4, D = 4, W = 16, ACC = 40, LN = 2, L = LN + 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ld_valid, ld_label, pw_valid, pw_done, tv_valid;
  logic [W-1:0] ld_data, pw_data, tv_data;
  logic [2:0] pw_addr;
  logic [1:0] phase;
  logic krow_valid, cls_valid, cls_out;
  logic [1:0] krow_idx;
  logic [N*ACC-1:0] krow_data;

  svm_bus_array u_svm_bus_array (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data), .ld_label(ld_label),
    .pw_valid(pw_valid), .pw_addr(pw_addr), .pw_data(pw_data), .pw_done(pw_done),
    .tv_valid(tv_valid), .tv_data(tv_data), .phase(phase), .krow_valid(krow_valid),
    .krow_idx(krow_idx), .krow_data(krow_data), .cls_valid(cls_valid), .cls_out(cls_out));

  int checks = 0, errors = 0, cyc = 0;
  int mph, lc, kc, tc, bia, nr, kr1, kr2;
  int vec [N][D];
  int lab [N];
  int alp [N];
  int tvb [D];
  int vin [N][D];
  int lin [N];
  logic kv1, kv2, nk, nc, no;
  logic [N*ACC-1:0] kd1, kd2, nd;
  logic cqv [1:L];
  logic cqo [1:L];

  function automatic logic [N*ACC-1:0] krow_of(int r);
    logic [N*ACC-1:0] res;
    for (int e = 0; e < N; e++) begin
      longint d = 0;
      for (int c = 0; c < D; c++) d += longint'(vec[r][c]) * vec[e][c];
      res[e*ACC +: ACC] = ACC'((d + 1) * (d + 1));
    end
    return res;
  endfunction

  function automatic logic class_of();
    longint s = bia;
    for (int m = 0; m < N; m++) begin
      longint d = 0;
      for (int c = 0; c < D; c++) d += longint'(tvb[c]) * vec[m][c];
      s += longint'(lab[m]) * alp[m] * (d + 1) * (d + 1);
    end
    return s > 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; lc = 0; kc = 0; tc = 0; bia = 0; kv1 = 0; kv2 = 0;
      for (int i = 0; i < N; i++) alp[i] = 0;
      for (int i = 1; i <= L; i++) begin cqv[i] = 0; cqo[i] = 0; end
    end else begin
      nk = 0; nc = 0; no = 0; nr = 0; nd = '0;
      case (mph)
        0: if (ld_valid) begin
             vec[lc/D][lc%D] = $signed(ld_data);
             if (lc % D == D - 1) lab[lc/D] = ld_label ? 1 : -1;
             if (lc == N*D - 1) begin mph = 1; lc = 0; end else lc++;
           end
        1: begin
             if (kc % D == D - 1) begin nk = 1; nr = kc / D; nd = krow_of(nr); end
             kc++;
             if (kc == N*D) begin mph = 2; kc = 0; end
           end
        2: begin
             if (pw_valid) begin
               if (pw_addr < N) alp[pw_addr] = int'(pw_data);
               else if (pw_addr == N) bia = $signed(pw_data);
             end
             if (pw_done) mph = 3;
           end
        default: if (tv_valid) begin
             tvb[tc] = $signed(tv_data);
             if (tc == D - 1) begin nc = 1; no = class_of(); tc = 0; end else tc++;
           end
      endcase
      kv2 = kv1; kr2 = kr1; kd2 = kd1; kv1 = nk; kr1 = nr; kd1 = nd;
      for (int i = L; i >= 2; i--) begin cqv[i] = cqv[i-1]; cqo[i] = cqo[i-1]; end
      cqv[1] = nc; cqo[1] = no;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [N*ACC-1:0] act, input logic [N*ACC-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "R1", "watchdog expired", '0, '0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst_n) begin
      chk(phase == 2'd0, "R1", "phase in reset", phase, 0);
      chk(!krow_valid && !cls_valid, "R1", "valids in reset", {krow_valid, cls_valid}, 0);
    end else begin
      chk(phase == mph[1:0], mph == 1 ? "R2" : mph == 3 ? "R6" : "R1", "phase", phase, mph);
      chk(krow_valid == kv2, "R3", "krow_valid", krow_valid, kv2);
      if (kv2) begin
        chk(krow_idx == kr2[1:0], "R3", "krow_idx", krow_idx, kr2);
        chk(krow_data == kd2, "R4", "krow_data", krow_data, kd2);
      end
      chk(cls_valid == cqv[L], "R7", "cls_valid", cls_valid, cqv[L]);
      if (cqv[L]) chk(cls_out == cqo[L], "R5/R8", "cls_out", cls_out, cqo[L]);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    ld_valid = 0; pw_valid = 0; pw_done = 0; tv_valid = 0;
  endtask

  task automatic load_all();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < D; c++) begin
        @(negedge clk);
        ld_valid = 1; ld_data = W'(vin[r][c]); ld_label = lin[r][0];
        if (r == 1 && c == 2) begin
          ld_valid = 0;
          @(negedge clk);
          ld_valid = 1;
        end
      end
    idle(1);
  endtask

  task automatic pw(input int a, input int v, input bit dn);
    @(negedge clk);
    pw_valid = 1; pw_addr = 3'(a); pw_data = W'(v); pw_done = dn;
    idle(1);
  endtask

  task automatic tv(input int a, input int b, input int c, input int d);
    int t [D];
    t = '{a, b, c, d};
    for (int i = 0; i < D; i++) begin
      @(negedge clk);
      tv_valid = 1; tv_data = W'(t[i]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle(3);
    rst_n = 1;
  endtask

  initial begin
    rst_n = 0; ld_valid = 0; ld_data = '0; ld_label = 0; pw_valid = 0; pw_addr = '0;
    pw_data = '0; pw_done = 0; tv_valid = 0; tv_data = '0;
    vin = '{'{1, 2, 0, -1}, '{-2, 1, 3, 0}, '{0, -1, -1, 2}, '{3, 0, -2, 1}};
    lin = '{1, 0, 1, 0};
    idle(3);
    rst_n = 1;
    // run 1: R2 load, R3/R4 kernel rows, R5 writes, R7 stray test beat in learn
    load_all();
    idle(20);
    pw(0, 2, 0); pw(1, 1, 0); pw(2, 3, 0); pw(3, 1, 0);
    @(negedge clk); tv_valid = 1; tv_data = 16'd7; idle(1);
    pw(4, -5, 1);
    // R7 back-to-back vectors, R8 both classes
    tv(0, -2, -2, 4); tv(0, 0, 0, 0); tv(1, 2, 0, -1); tv(3, 0, -2, 1);
    idle(1); idle(L + 2);
    // R5 write during recall must not change the result
    pw(0, 999, 0);
    tv(0, 0, 0, 0); idle(1); idle(L + 2);

    // run 2: reset clears, R5 ignored writes, R8 exact zero sum
    do_reset();
    lin = '{1, 0, 1, 1};
    pw(2, 50, 0);
    load_all();
    @(negedge clk); ld_valid = 1; ld_data = 16'd99; idle(1);
    idle(20);
    pw(0, 3, 0); pw(1, 3, 0); pw(5, 100, 0);
    pw(4, 0, 1);
    tv(0, 0, 0, 0); tv(-1, 1, 2, 0); idle(1); idle(L + 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule